// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block takes message-signalled interrupts from PCIe endpoints and merges them into a single level interrupt for a host interrupt controller. Each vector owns its own 32-bit doorbell word on a memory-mapped vector port. An endpoint's posted write to that word raises the vector. Software acknowledges a vector by reading the same word back.

A second memory-mapped port carries three control words: the pending vectors, a record of doorbell writes that fell outside the configured vector range, and the per-vector enable mask. The number of vectors is fixed at build time, up to 32, and no register reports it.

A service routine reads the pending word and acknowledges each set bit from the lowest upwards through its doorbell slot. It then reads the pending word again until it reads zero. A pending bit is held whether or not its vector is enabled, so enabling a vector later raises the interrupt straight away.

Top module: `msi_doorbell_agg`

## Requirements
- R1: After reset, the pending word, the error word and the enable mask all read zero, and `irq_o` is low.
- R2: A doorbell write to byte offset 4*n of the vector port, with n below the vector count, sets bit n of the pending word at control offset 0x0.
- R3: A doorbell read of byte offset 4*n returns the previous state of pending bit n in bit 0 of the read data, with all other bits zero, and clears that pending bit. A read of a vector that is not pending returns zero.
- R4: If a doorbell write and a doorbell read address the same vector in the same cycle, the bit stays set, and the read returns the state the bit had before that cycle.
- R5: Bit n of the enable mask at control offset 0x8 enables vector n when 1. Pending bits latch regardless of the mask.
- R6: `irq_o` is high exactly when, on the previous clock edge, some vector was both pending and enabled. It therefore rises two edges after the doorbell write that presents the first enabled vector, and falls two edges after the acknowledging read or the mask write.
- R7: A doorbell write to an index at or above the vector count changes no pending bit. It sets the bit of the same index in the error word at control offset 0x4. A control write to the error word clears each bit whose data bit is 1 and leaves the others unchanged.
- R8: Bits of the pending word and the enable mask at or above the vector count always read zero, including after a write of all ones to the mask.
- R9: Read data on either port appears on the clock edge after the read request. A control read at offset 0xC returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_wr_en | input | 1 | Doorbell write strobe |
| vec_wr_addr | input | 7 | Doorbell write byte address (word index in bits 6:2) |
| vec_wr_data | input | 32 | Doorbell message data (carries the vector number; not decoded) |
| vec_rd_en | input | 1 | Doorbell read (acknowledge) strobe |
| vec_rd_addr | input | 7 | Doorbell read byte address |
| vec_rd_data | output | 32 | Doorbell read data, one cycle after the request |
| csr_wr_en | input | 1 | Control write strobe |
| csr_rd_en | input | 1 | Control read strobe |
| csr_addr | input | 4 | Control byte address |
| csr_wr_data | input | 32 | Control write data |
| csr_rd_data | output | 32 | Control read data, one cycle after the request |
| irq_o | output | 1 | Merged level interrupt |

## Verification
A doorbell write or acknowledge changes the pending state on the edge that samples it, and the read data of either port is due one edge after the request. The interrupt line follows one edge later than the pending and mask state, so it is due two edges after the stimulus. The bench drives every input on the falling edge. The scoreboard checks a read response on the falling edge that follows the rising edge answering the request. The bench checks the interrupt one full cycle after the task that changed pending or mask state has returned.

// File: rtl/msi_agg_pkg.sv
// Package: shared sizes and the control-word selector for the MSI
// doorbell aggregator. Assumes a 32-bit word and at most 32 vectors.
package msi_agg_pkg;
    localparam int MAX_VEC = 32;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(MAX_VEC);
    localparam int VADDR_W = IDX_W + 2;
    localparam int CADDR_W = 4;

    // Control word selected by byte-address bits [3:2].
    typedef enum logic [1:0] {
        CSR_STATUS = 2'd0,
        CSR_ERROR  = 2'd1,
        CSR_MASK   = 2'd2,
        CSR_NONE   = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/msi_doorbell_decode.sv
// Doorbell decoder: turns the vector-port write and read strobes into
// one-hot set and clear vectors for the configured vectors, plus a
// one-hot error vector for writes beyond the configured count.
// Assumes byte addresses with the word index in bits [VADDR_W-1:2].
module msi_doorbell_decode
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               wr_en,
    input  logic [VADDR_W-1:0] wr_addr,
    input  logic               rd_en,
    input  logic [VADDR_W-1:0] rd_addr,
    output logic [NUM_VEC-1:0] set_vec,
    output logic [NUM_VEC-1:0] clr_vec,
    output logic [MAX_VEC-1:0] oor_vec
);
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             unused_lsb;

    assign wr_idx     = wr_addr[VADDR_W-1:2];
    assign rd_idx     = rd_addr[VADDR_W-1:2];
    assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

    // One set/clear decode per configured vector.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign set_vec[v] = wr_en && (wr_idx == IDX_W'(v));
        assign clr_vec[v] = rd_en && (rd_idx == IDX_W'(v));
    end

    // Error decode only exists for indices past the configured count.
    for (genvar e = 0; e < MAX_VEC; e++) begin : g_oor
        if (e >= NUM_VEC) begin : g_live
            assign oor_vec[e] = wr_en && (wr_idx == IDX_W'(e));
        end else begin : g_dead
            assign oor_vec[e] = 1'b0;
        end
    end
endmodule

// File: rtl/msi_pending_bank.sv
// Pending bank: one flop per vector that is set by a doorbell write and
// cleared by a doorbell read; a set in the same cycle wins over the clear.
module msi_pending_bank #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] clr_vec,
    output logic [NUM_VEC-1:0] pend_q
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
        // Latch or acknowledge vector v, set taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[v] <= 1'b0;
            else if (set_vec[v]) pend_q[v] <= 1'b1;
            else if (clr_vec[v]) pend_q[v] <= 1'b0;
        end
    end
endmodule

// File: rtl/msi_csr_regs.sv
// Control words: enable mask, write-one-to-clear error word and the
// registered read multiplexer for pending, error and mask.
// Assumes a single-cycle write and a read answered on the next edge.
module msi_csr_regs
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [CADDR_W-1:0] addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [MAX_VEC-1:0] err_set,
    output logic [NUM_VEC-1:0] mask_q,
    output logic [MAX_VEC-1:0] err_q,
    output logic [WORD_W-1:0]  rdata
);
    csr_sel_e           sel;
    logic [MAX_VEC-1:0] err_clr;
    logic               unused_bits;

    assign sel         = csr_sel_e'(addr[3:2]);
    assign err_clr     = (wr_en && sel == CSR_ERROR) ? wdata[MAX_VEC-1:0] : '0;
    assign unused_bits = ^{addr[1:0], wdata};

    // Enable mask: only configured vectors have storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= '0;
        else if (wr_en && sel == CSR_MASK) mask_q <= wdata[NUM_VEC-1:0];
    end

    // Error word: new captures win over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    // Registered read data, zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                CSR_STATUS: rdata <= WORD_W'(pend);
                CSR_ERROR:  rdata <= WORD_W'(err_q);
                CSR_MASK:   rdata <= WORD_W'(mask_q);
                default:    rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/msi_irq_merge.sv
// Interrupt merge: registered OR of all pending-and-enabled vectors.
module msi_irq_merge #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] mask,
    output logic               irq_q
);
    // Level output, one edge behind the pending and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & mask);
    end
endmodule

// File: rtl/msi_doorbell_agg.sv
// Top: MSI doorbell aggregator. Wires the decoder, pending bank, control
// words and interrupt merge, and registers the doorbell read data.
// Assumes NUM_VEC between 1 and MAX_VEC and synchronous active-low reset.
module msi_doorbell_agg
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_wr_en,
    input  logic [VADDR_W-1:0] vec_wr_addr,
    input  logic [WORD_W-1:0]  vec_wr_data,
    input  logic               vec_rd_en,
    input  logic [VADDR_W-1:0] vec_rd_addr,
    output logic [WORD_W-1:0]  vec_rd_data,
    input  logic               csr_wr_en,
    input  logic               csr_rd_en,
    input  logic [CADDR_W-1:0] csr_addr,
    input  logic [WORD_W-1:0]  csr_wr_data,
    output logic [WORD_W-1:0]  csr_rd_data,
    output logic               irq_o
);
    logic [NUM_VEC-1:0] set_w;
    logic [NUM_VEC-1:0] clr_w;
    logic [MAX_VEC-1:0] oor_w;
    logic [NUM_VEC-1:0] pend_w;
    logic [NUM_VEC-1:0] mask_w;
    logic [MAX_VEC-1:0] err_w;
    logic               unused_msg;

    assign unused_msg = ^vec_wr_data;

    msi_doorbell_decode #(.NUM_VEC(NUM_VEC)) u_decode (
        .wr_en   (vec_wr_en),
        .wr_addr (vec_wr_addr),
        .rd_en   (vec_rd_en),
        .rd_addr (vec_rd_addr),
        .set_vec (set_w),
        .clr_vec (clr_w),
        .oor_vec (oor_w)
    );

    msi_pending_bank #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_w),
        .clr_vec (clr_w),
        .pend_q  (pend_w)
    );

    msi_csr_regs #(.NUM_VEC(NUM_VEC)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .rd_en   (csr_rd_en),
        .addr    (csr_addr),
        .wdata   (csr_wr_data),
        .pend    (pend_w),
        .err_set (oor_w),
        .mask_q  (mask_w),
        .err_q   (err_w),
        .rdata   (csr_rd_data)
    );

    msi_irq_merge #(.NUM_VEC(NUM_VEC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_w),
        .mask  (mask_w),
        .irq_q (irq_o)
    );

    // Doorbell read data: prior pending state of the addressed vector.
    always_ff @(posedge clk) begin
        if (!rst_n)         vec_rd_data <= '0;
        else if (vec_rd_en) vec_rd_data <= WORD_W'(|(pend_w & clr_w));
        else                vec_rd_data <= '0;
    end
endmodule

// File: rtl/msi_doorbell_agg_chk.sv
// Checker: temporal properties of the doorbell aggregator, bound to the
// top. Observes ports and the pending, mask and error state.
module msi_doorbell_agg_chk
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_wr_en,
    input logic [VADDR_W-1:0] vec_wr_addr,
    input logic               vec_rd_en,
    input logic [VADDR_W-1:0] vec_rd_addr,
    input logic               csr_rd_en,
    input logic [CADDR_W-1:0] csr_addr,
    input logic [WORD_W-1:0]  csr_rd_data,
    input logic               irq_o,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] mask,
    input logic [MAX_VEC-1:0] err
);
    localparam logic [WORD_W-1:0] VALID =
        (NUM_VEC >= WORD_W) ? '1 : ((WORD_W'(1) << NUM_VEC) - WORD_W'(1));

    logic [IDX_W-1:0]   wi;
    logic [IDX_W-1:0]   ri;
    logic [MAX_VEC-1:0] pend_x;

    assign wi     = vec_wr_addr[VADDR_W-1:2];
    assign ri     = vec_rd_addr[VADDR_W-1:2];
    assign pend_x = MAX_VEC'(pend);

    // R1: reset empties pending state and drops the interrupt.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && pend == '0 && err == '0));

    // R2: an in-range doorbell write leaves its pending bit set.
    a_r2_doorbell_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr_en && 32'(wi) < NUM_VEC) |=> pend_x[$past(wi)]);

    // R3: an acknowledge with no competing set clears the bit.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_en && 32'(ri) < NUM_VEC && !(vec_wr_en && wi == ri))
        |=> !pend_x[$past(ri)]);

    // R4: a set and a clear of one vector in one cycle keep the bit.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr_en && vec_rd_en && wi == ri && 32'(wi) < NUM_VEC)
        |=> pend_x[$past(wi)]);

    // R6: interrupt follows pending-and-enabled one edge later.
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend & mask))));

    // R7: an out-of-range doorbell write is recorded in the error word.
    a_r7_oor_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_wr_en && 32'(wi) >= NUM_VEC) |=> err[$past(wi)]);

    // R8: status and mask reads never show bits past the vector count.
    a_r8_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd_en && csr_addr[3:2] != 2'd1) |=> ((csr_rd_data & ~VALID) == '0));
endmodule

bind msi_doorbell_agg msi_doorbell_agg_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_wr_en   (vec_wr_en),
    .vec_wr_addr (vec_wr_addr),
    .vec_rd_en   (vec_rd_en),
    .vec_rd_addr (vec_rd_addr),
    .csr_rd_en   (csr_rd_en),
    .csr_addr    (csr_addr),
    .csr_rd_data (csr_rd_data),
    .irq_o       (irq_o),
    .pend        (pend_w),
    .mask        (mask_w),
    .err         (err_w)
);

// File: tb/msi_doorbell_agg_tb.sv
// Scoreboard bench: driver tasks push expected read data into queues,
// a falling-edge monitor pops and compares the registered responses.
module msi_doorbell_agg_tb;
    import msi_agg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 24;
    localparam logic [31:0] VALID = (32'd1 << NV) - 32'd1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vec_wr_en = 1'b0;
    logic [VADDR_W-1:0] vec_wr_addr = '0;
    logic [WORD_W-1:0]  vec_wr_data = '0;
    logic               vec_rd_en = 1'b0;
    logic [VADDR_W-1:0] vec_rd_addr = '0;
    logic [WORD_W-1:0]  vec_rd_data;
    logic               csr_wr_en = 1'b0;
    logic               csr_rd_en = 1'b0;
    logic [CADDR_W-1:0] csr_addr = '0;
    logic [WORD_W-1:0]  csr_wr_data = '0;
    logic [WORD_W-1:0]  csr_rd_data;
    logic               irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_pend = '0;
    logic [31:0] m_mask = '0;
    logic [31:0] m_err  = '0;

    logic [31:0] csr_exp_q[$];
    string       csr_tag_q[$];
    logic [31:0] vec_exp_q[$];
    string       vec_tag_q[$];
    logic        due_c = 1'b0;
    logic        due_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_doorbell_agg #(.NUM_VEC(NV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vec_wr_en(vec_wr_en), .vec_wr_addr(vec_wr_addr), .vec_wr_data(vec_wr_data),
        .vec_rd_en(vec_rd_en), .vec_rd_addr(vec_rd_addr), .vec_rd_data(vec_rd_data),
        .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en), .csr_addr(csr_addr),
        .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data), .irq_o(irq_o)
    );

    task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Response due flags: a request seen at a rising edge is answered there.
    always @(posedge clk) begin
        due_c <= csr_rd_en;
        due_v <= vec_rd_en;
    end

    // Monitor: compare each response against the front of its queue.
    always @(negedge clk) begin
        if (due_c) begin
            if (csr_exp_q.size() == 0) compare("R9 unexpected control response", csr_rd_data, 32'hx);
            else compare(csr_tag_q.pop_front(), csr_rd_data, csr_exp_q.pop_front());
        end
        if (due_v) begin
            if (vec_exp_q.size() == 0) compare("R9 unexpected doorbell response", vec_rd_data, 32'hx);
            else compare(vec_tag_q.pop_front(), vec_rd_data, vec_exp_q.pop_front());
        end
    end

    // Driver tasks: start just after a falling edge, hold for one cycle.
    task automatic door_wr(input int idx);
        vec_wr_en = 1'b1; vec_wr_addr = VADDR_W'(idx * 4); vec_wr_data = 32'(idx);
        if (idx < NV) m_pend[idx] = 1'b1; else m_err[idx] = 1'b1;
        @(negedge clk);
        vec_wr_en = 1'b0;
    endtask

    task automatic door_rd(input int idx, input string tag);
        vec_rd_en = 1'b1; vec_rd_addr = VADDR_W'(idx * 4);
        vec_exp_q.push_back((idx < NV) ? 32'(m_pend[idx]) : 32'd0);
        vec_tag_q.push_back(tag);
        if (idx < NV) m_pend[idx] = 1'b0;
        @(negedge clk);
        vec_rd_en = 1'b0;
    endtask

    task automatic door_both(input int idx, input string tag);
        vec_wr_en = 1'b1; vec_rd_en = 1'b1;
        vec_wr_addr = VADDR_W'(idx * 4); vec_rd_addr = VADDR_W'(idx * 4);
        vec_wr_data = 32'(idx);
        vec_exp_q.push_back(32'(m_pend[idx]));
        vec_tag_q.push_back(tag);
        m_pend[idx] = 1'b1;
        @(negedge clk);
        vec_wr_en = 1'b0; vec_rd_en = 1'b0;
    endtask

    task automatic csr_wr(input int addr, input logic [31:0] data);
        csr_wr_en = 1'b1; csr_addr = CADDR_W'(addr); csr_wr_data = data;
        if (addr == 8) m_mask = data & VALID;
        if (addr == 4) m_err  = m_err & ~data;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic csr_rd(input int addr, input string tag);
        logic [31:0] e;
        case (addr)
            0:       e = m_pend;
            4:       e = m_err;
            8:       e = m_mask;
            default: e = 32'd0;
        endcase
        csr_rd_en = 1'b1; csr_addr = CADDR_W'(addr);
        csr_exp_q.push_back(e);
        csr_tag_q.push_back(tag);
        @(negedge clk);
        csr_rd_en = 1'b0;
    endtask

    // The interrupt is due one cycle after the state-changing task returns.
    task automatic irq_due(input logic exp, input string tag);
        @(negedge clk);
        compare(tag, 32'(irq_o), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 irq after reset", 32'(irq_o), 32'd0);
        csr_rd(0, "R1 pending after reset");
        csr_rd(4, "R1 error after reset");
        csr_rd(8, "R1 mask after reset");

        door_wr(5);
        irq_due(1'b0, "R5 masked vector keeps irq low");
        csr_rd(0, "R2 pending bit 5");
        compare("R2 model bit 5", m_pend, 32'h20);

        csr_wr(8, 32'h20);
        irq_due(1'b1, "R5/R6 enabling pending vector raises irq");
        csr_rd(8, "R5 mask readback");

        door_rd(5, "R3 acknowledge returns pending");
        irq_due(1'b0, "R6 irq drops after acknowledge");
        csr_rd(0, "R3 pending cleared");
        door_rd(5, "R3 acknowledge of idle vector");

        door_wr(3); door_wr(7); door_wr(20);
        csr_rd(0, "R2 three vectors pending");
        door_rd(3, "R3 acknowledge lowest first");
        csr_rd(0, "R3 only vector 3 cleared");

        door_both(7, "R4 same-cycle set and ack of pending vector");
        csr_rd(0, "R4 vector 7 still pending");
        door_both(9, "R4 same-cycle set and ack of idle vector");
        csr_rd(0, "R4 vector 9 now pending");

        irq_due(1'b0, "R6 no enabled vector pending");
        csr_wr(8, 32'h0010_0000);
        irq_due(1'b1, "R6 irq on enabling vector 20");
        door_rd(20, "R3 acknowledge vector 20");
        irq_due(1'b0, "R6 irq drops after vector 20 ack");

        door_wr(30);
        csr_rd(4, "R7 error bit 30 captured");
        csr_rd(0, "R7 pending untouched by out-of-range write");
        door_wr(25);
        csr_rd(4, "R7 error bits 30 and 25");
        csr_wr(4, 32'h0);
        csr_rd(4, "R7 zero write keeps error bits");
        csr_wr(4, 32'h4000_0000);
        csr_rd(4, "R7 write-one clears only bit 30");
        door_rd(30, "R7 out-of-range acknowledge reads zero");

        csr_wr(8, 32'hFFFF_FFFF);
        csr_rd(8, "R8 mask bits past count read zero");
        compare("R8 model mask", m_mask, 32'h00FF_FFFF);
        door_wr(23);
        csr_rd(0, "R8 top configured vector pending");
        irq_due(1'b1, "R6 irq with all vectors enabled");

        csr_rd(12, "R9 unmapped control offset reads zero");
        repeat (2) @(negedge clk);
        compare("R9 all responses arrived", 32'(csr_exp_q.size() + vec_exp_q.size()), 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule